// File: doc/BRIEF.md
# Receive Frame Length Checker

This block watches the byte stream of the receive path, one byte per beat, and judges each frame when its last byte arrives. It counts the bytes from the start-of-frame beat to the end-of-frame beat. On the way it captures the two-byte length/type field. On the end beat it decides whether the frame is kept or thrown away. The frame is discarded when it is longer than the selected maximum size, shorter than the minimum size, shorter than its own length field says, or when it carries a CRC, alignment or symbol error. The last three errors are reported by the upstream logic on the end beat.

Each verdict appears as a one-cycle strobe. The strobe carries an accept bit and one flag per length or CRC fault class. Four 8-bit statistics counters track the oversize, undersize, length-mismatch and CRC-error classes. The counters stop at all ones. A single-cycle statistics clear returns them to zero. The static configuration inputs choose the size limit, turn length-field checking on or off, and decide whether CRC errors are tolerated. They are sampled on the end beat.

Top module: `rx_len_checker`

## Requirements
- R1: A beat with `rx_valid` high and `rx_eof` high that ends a frame in progress produces `verdict_valid` high for exactly the next cycle. Beats with `rx_valid` high that arrive outside a frame, when no start beat was seen, are ignored, including end beats. Such beats produce no verdict.
- R2: The frame length is the number of beats with `rx_valid` high from the start beat to the end beat, both included. Beats with `rx_valid` low do not count. A new start beat inside a frame drops the partial frame and restarts the count at that beat.
- R3: The size limit is 1518 bytes by default and 1536 bytes with `cfg_ext_size`. With `cfg_jumbo` it is 10240 bytes, and `cfg_jumbo` wins over `cfg_ext_size`. A frame longer than the limit raises `err_oversize` and is discarded. A frame of exactly the limit passes this test.
- R4: The length/type field is formed big-endian from the bytes at zero-based offsets 12 (high) and 13 (low). An offset the frame does not reach reads as zero. With `cfg_len_check` high, a field below 0x0600 that is larger than the payload raises `err_len_mismatch` and the frame is discarded. The payload is the frame length minus 18, or 0 when the frame is 18 bytes or fewer. A field of 0x0600 or more is never flagged. With `cfg_len_check` low the flag never rises.
- R5: A frame shorter than 64 bytes is always discarded. It raises `err_undersize` only if `rx_fcs_err`, `rx_align_err` and `rx_sym_err` are all low on its end beat.
- R6: With `cfg_fcs_ignore` low, `rx_fcs_err` on the end beat raises `err_fcs` and discards the frame. With `cfg_fcs_ignore` high, a CRC error neither raises the flag nor discards the frame.
- R7: `rx_align_err` or `rx_sym_err` on the end beat discards the frame without raising any of the four flags.
- R8: Each counter is 8 bits wide. It rises by one, in the same cycle as the verdict, for every verdict carrying its flag. It holds at 255 once it gets there.
- R9: `clr_stats` high at a clock edge sets all four counters to zero at that edge, even when a flagged verdict would have advanced them at the same edge.
- R10: While `rst` is high, every output is zero and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | Byte beat valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_fcs_err | input | 1 | CRC error, sampled on the end beat |
| rx_align_err | input | 1 | Alignment error, sampled on the end beat |
| rx_sym_err | input | 1 | Symbol error, sampled on the end beat |
| cfg_ext_size | input | 1 | Raise the size limit to 1536 bytes |
| cfg_jumbo | input | 1 | Raise the size limit to 10240 bytes |
| cfg_len_check | input | 1 | Enable length-field checking |
| cfg_fcs_ignore | input | 1 | Tolerate CRC errors |
| clr_stats | input | 1 | Synchronous counter clear |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame kept, valid with the strobe |
| err_oversize | output | 1 | Oversize class flag |
| err_undersize | output | 1 | Undersize class flag |
| err_len_mismatch | output | 1 | Length-field mismatch flag |
| err_fcs | output | 1 | CRC error class flag |
| cnt_oversize | output | 8 | Oversize frame count |
| cnt_undersize | output | 8 | Undersize frame count |
| cnt_len_mismatch | output | 8 | Length mismatch count |
| cnt_fcs | output | 8 | CRC error count |

## Verification
A wrong byte count, or a field captured from the wrong offset, shows up on the very strobe that ends the frame. It appears there as a wrong accept bit or a wrong flag. It shows only when the frame sits at a threshold, so the frames are placed one byte on each side of every limit. A frame-tracking state that is stuck or stale shows up as a strobe where none is due, or a missing one, one cycle after the end beat. The counters are compared on every cycle, so a lost increment, a wrap past 255 or a clear that loses to an increment is seen in the cycle it happens.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  // outcome of one frame, evaluated on its end beat
  typedef struct packed {
    logic oversize;
    logic undersize;
    logic mismatch;
    logic fcs;
    logic drop;
  } rlc_class_t;

  localparam int unsigned NUM_CNT = 4;
  // counter slot assignment
  localparam int unsigned SLOT_OVER  = 0;
  localparam int unsigned SLOT_UNDER = 1;
  localparam int unsigned SLOT_MISM  = 2;
  localparam int unsigned SLOT_FCS   = 3;
endpackage

// File: rtl/rlc_byte_track.sv
module rlc_byte_track #(
  parameter int unsigned LEN_W     = 14,
  parameter int unsigned FIELD_POS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  output logic             frame_end,
  output logic [LEN_W-1:0] len_now,
  output logic [15:0]      field_now
);
  logic             in_frame;
  logic [LEN_W-1:0] len_q;
  logic [15:0]      field_q;
  logic             beat_in;
  logic [LEN_W-1:0] base_len;
  logic [15:0]      field_base;

  assign beat_in    = rx_valid & (rx_sof | in_frame);
  assign base_len   = rx_sof ? '0 : len_q;
  assign field_base = rx_sof ? '0 : field_q;
  assign frame_end  = beat_in & rx_eof;

  always_comb begin
    len_now   = len_q;
    field_now = field_q;
    if (beat_in) begin
      len_now   = (base_len == '1) ? base_len : base_len + 1'b1;
      field_now = field_base;
      if (base_len == LEN_W'(FIELD_POS))
        field_now = {rx_data, field_base[7:0]};
      else if (base_len == LEN_W'(FIELD_POS + 1))
        field_now = {field_base[15:8], rx_data};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      len_q    <= '0;
      field_q  <= '0;
    end else if (beat_in) begin
      in_frame <= ~rx_eof;
      len_q    <= len_now;
      field_q  <= field_now;
    end
  end
endmodule

// File: rtl/rlc_classify.sv
module rlc_classify
  import rlc_pkg::*;
#(
  parameter int unsigned LEN_W       = 14,
  parameter int unsigned LIM_STD     = 1518,
  parameter int unsigned LIM_EXT     = 1536,
  parameter int unsigned LIM_JUMBO   = 10240,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned OVERHEAD    = 18,
  parameter int unsigned TYPE_THRESH = 16'h0600
) (
  input  logic [LEN_W-1:0] len,
  input  logic [15:0]      field,
  input  logic             cfg_ext_size,
  input  logic             cfg_jumbo,
  input  logic             cfg_len_check,
  input  logic             cfg_fcs_ignore,
  input  logic             fcs_err,
  input  logic             align_err,
  input  logic             sym_err,
  output rlc_class_t       cls
);
  logic [31:0] len32;
  logic [31:0] limit;
  logic [31:0] payload;
  logic        short_frame;

  assign len32 = 32'(len);

  always_comb begin
    if (cfg_jumbo)         limit = LIM_JUMBO;
    else if (cfg_ext_size) limit = LIM_EXT;
    else                   limit = LIM_STD;
    payload     = (len32 > OVERHEAD) ? len32 - OVERHEAD : 32'd0;
    short_frame = len32 < MIN_LEN;

    cls.oversize  = len32 > limit;
    cls.mismatch  = cfg_len_check && (32'(field) < TYPE_THRESH)
                    && (32'(field) > payload);
    cls.undersize = short_frame & ~fcs_err & ~align_err & ~sym_err;
    cls.fcs       = fcs_err & ~cfg_fcs_ignore;
    cls.drop      = cls.oversize | cls.mismatch | cls.fcs | short_frame
                    | align_err | sym_err;
  end
endmodule

// File: rtl/rlc_sat_cnt.sv
module rlc_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && (cnt != '1))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_len_checker.sv
module rx_len_checker
  import rlc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LIM_STD     = 1518,
  parameter int unsigned LIM_EXT     = 1536,
  parameter int unsigned LIM_JUMBO   = 10240,
  parameter int unsigned MIN_LEN     = 64,
  parameter int unsigned OVERHEAD    = 18,
  parameter int unsigned FIELD_POS   = 12,
  parameter int unsigned TYPE_THRESH = 16'h0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic             rx_fcs_err,
  input  logic             rx_align_err,
  input  logic             rx_sym_err,
  input  logic             cfg_ext_size,
  input  logic             cfg_jumbo,
  input  logic             cfg_len_check,
  input  logic             cfg_fcs_ignore,
  input  logic             clr_stats,
  output logic             verdict_valid,
  output logic             verdict_accept,
  output logic             err_oversize,
  output logic             err_undersize,
  output logic             err_len_mismatch,
  output logic             err_fcs,
  output logic [CNT_W-1:0] cnt_oversize,
  output logic [CNT_W-1:0] cnt_undersize,
  output logic [CNT_W-1:0] cnt_len_mismatch,
  output logic [CNT_W-1:0] cnt_fcs
);
  localparam int unsigned LEN_W = $clog2(LIM_JUMBO + 2);

  logic             frame_end;
  logic [LEN_W-1:0] len_now;
  logic [15:0]      field_now;
  rlc_class_t       cls;
  logic [NUM_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  rlc_byte_track #(.LEN_W(LEN_W), .FIELD_POS(FIELD_POS)) u_track (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .frame_end(frame_end),
    .len_now(len_now), .field_now(field_now)
  );

  rlc_classify #(
    .LEN_W(LEN_W), .LIM_STD(LIM_STD), .LIM_EXT(LIM_EXT),
    .LIM_JUMBO(LIM_JUMBO), .MIN_LEN(MIN_LEN), .OVERHEAD(OVERHEAD),
    .TYPE_THRESH(TYPE_THRESH)
  ) u_class (
    .len(len_now), .field(field_now), .cfg_ext_size(cfg_ext_size),
    .cfg_jumbo(cfg_jumbo), .cfg_len_check(cfg_len_check),
    .cfg_fcs_ignore(cfg_fcs_ignore), .fcs_err(rx_fcs_err),
    .align_err(rx_align_err), .sym_err(rx_sym_err), .cls(cls)
  );

  always_comb begin
    cnt_inc             = '0;
    cnt_inc[SLOT_OVER]  = frame_end & cls.oversize;
    cnt_inc[SLOT_UNDER] = frame_end & cls.undersize;
    cnt_inc[SLOT_MISM]  = frame_end & cls.mismatch;
    cnt_inc[SLOT_FCS]   = frame_end & cls.fcs;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    rlc_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr_stats), .inc(cnt_inc[g]),
      .cnt(cnt_arr[g])
    );
  end

  assign cnt_oversize     = cnt_arr[SLOT_OVER];
  assign cnt_undersize    = cnt_arr[SLOT_UNDER];
  assign cnt_len_mismatch = cnt_arr[SLOT_MISM];
  assign cnt_fcs          = cnt_arr[SLOT_FCS];

  always_ff @(posedge clk) begin
    if (rst) begin
      verdict_valid    <= 1'b0;
      verdict_accept   <= 1'b0;
      err_oversize     <= 1'b0;
      err_undersize    <= 1'b0;
      err_len_mismatch <= 1'b0;
      err_fcs          <= 1'b0;
    end else begin
      verdict_valid    <= frame_end;
      verdict_accept   <= frame_end & ~cls.drop;
      err_oversize     <= frame_end & cls.oversize;
      err_undersize    <= frame_end & cls.undersize;
      err_len_mismatch <= frame_end & cls.mismatch;
      err_fcs          <= frame_end & cls.fcs;
    end
  end
endmodule

// File: rtl/rx_len_checker_chk.sv
module rx_len_checker_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_eof,
  input logic             clr_stats,
  input logic             verdict_valid,
  input logic             verdict_accept,
  input logic             err_oversize,
  input logic             err_undersize,
  input logic             err_len_mismatch,
  input logic             err_fcs,
  input logic [CNT_W-1:0] cnt_oversize,
  input logic [CNT_W-1:0] cnt_undersize,
  input logic [CNT_W-1:0] cnt_len_mismatch,
  input logic [CNT_W-1:0] cnt_fcs
);
  logic any_flag;
  assign any_flag = err_oversize | err_undersize | err_len_mismatch | err_fcs;

  // R1
  strobe_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_valid |-> $past(rx_valid && rx_eof));

  // R1
  quiet_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !verdict_valid |-> !(any_flag || verdict_accept));

  // R6
  accept_clean_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_accept |-> !any_flag);

  // R5
  undersize_excl_chk: assert property (@(posedge clk) disable iff (rst)
    err_undersize |-> !err_fcs);

  // R9
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_stats) |-> (cnt_oversize == '0 && cnt_undersize == '0
                          && cnt_len_mismatch == '0 && cnt_fcs == '0));

  // R8
  over_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_stats) && cnt_oversize != $past(cnt_oversize))
      |-> (err_oversize && cnt_oversize == $past(cnt_oversize) + 1'b1));

  // R8
  under_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_stats) && cnt_undersize != $past(cnt_undersize))
      |-> (err_undersize && cnt_undersize == $past(cnt_undersize) + 1'b1));

  // R8
  mism_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_stats) && cnt_len_mismatch != $past(cnt_len_mismatch))
      |-> (err_len_mismatch && cnt_len_mismatch == $past(cnt_len_mismatch) + 1'b1));

  // R8
  fcs_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_stats) && cnt_fcs != $past(cnt_fcs))
      |-> (err_fcs && cnt_fcs == $past(cnt_fcs) + 1'b1));
endmodule

bind rx_len_checker rx_len_checker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .clr_stats(clr_stats), .verdict_valid(verdict_valid),
  .verdict_accept(verdict_accept), .err_oversize(err_oversize),
  .err_undersize(err_undersize), .err_len_mismatch(err_len_mismatch),
  .err_fcs(err_fcs), .cnt_oversize(cnt_oversize),
  .cnt_undersize(cnt_undersize), .cnt_len_mismatch(cnt_len_mismatch),
  .cnt_fcs(cnt_fcs)
);

// File: tb/rx_len_checker_tb.sv
module rx_len_checker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 8'h00;
  logic rx_fcs_err = 0, rx_align_err = 0, rx_sym_err = 0;
  logic cfg_ext_size = 0, cfg_jumbo = 0, cfg_len_check = 0, cfg_fcs_ignore = 0;
  logic clr_stats = 0;
  logic verdict_valid, verdict_accept;
  logic err_oversize, err_undersize, err_len_mismatch, err_fcs;
  logic [7:0] cnt_oversize, cnt_undersize, cnt_len_mismatch, cnt_fcs;

  int errors = 0;
  int checks = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;

  rx_len_checker u_dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_fcs_err(rx_fcs_err),
    .rx_align_err(rx_align_err), .rx_sym_err(rx_sym_err),
    .cfg_ext_size(cfg_ext_size), .cfg_jumbo(cfg_jumbo),
    .cfg_len_check(cfg_len_check), .cfg_fcs_ignore(cfg_fcs_ignore),
    .clr_stats(clr_stats), .verdict_valid(verdict_valid),
    .verdict_accept(verdict_accept), .err_oversize(err_oversize),
    .err_undersize(err_undersize), .err_len_mismatch(err_len_mismatch),
    .err_fcs(err_fcs), .cnt_oversize(cnt_oversize),
    .cnt_undersize(cnt_undersize), .cnt_len_mismatch(cnt_len_mismatch),
    .cnt_fcs(cnt_fcs)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] frame_q[$];
  bit in_frame = 0;
  bit e_valid, e_acc, e_over, e_under, e_mism, e_fcs;
  int c_over, c_under, c_mism, c_fcs;

  always @(posedge clk) begin
    if (rst) begin
      frame_q.delete();
      in_frame = 0;
      {e_valid, e_acc, e_over, e_under, e_mism, e_fcs} = '0;
      c_over = 0; c_under = 0; c_mism = 0; c_fcs = 0;
    end else begin
      {e_valid, e_acc, e_over, e_under, e_mism, e_fcs} = '0;
      if (rx_valid && (rx_sof || in_frame)) begin
        if (rx_sof) frame_q.delete();
        frame_q.push_back(rx_data);
        in_frame = !rx_eof;
        if (rx_eof) begin
          int n, lim, pay, fld;
          bit shrt;
          n   = frame_q.size();
          fld = 0;
          if (n > 12) fld = int'(frame_q[12]) * 256;
          if (n > 13) fld = fld + int'(frame_q[13]);
          lim = cfg_jumbo ? 10240 : (cfg_ext_size ? 1536 : 1518);
          pay = (n > 18) ? n - 18 : 0;
          shrt    = n < 64;
          e_valid = 1;
          e_over  = n > lim;
          e_mism  = cfg_len_check && fld < 'h600 && fld > pay;
          e_under = shrt && !rx_fcs_err && !rx_align_err && !rx_sym_err;
          e_fcs   = rx_fcs_err && !cfg_fcs_ignore;
          e_acc   = !(e_over || e_mism || e_fcs || shrt || rx_align_err || rx_sym_err);
          if (e_over  && c_over  < 255) c_over++;
          if (e_under && c_under < 255) c_under++;
          if (e_mism  && c_mism  < 255) c_mism++;
          if (e_fcs   && c_fcs   < 255) c_fcs++;
        end
      end
      if (clr_stats) begin
        c_over = 0; c_under = 0; c_mism = 0; c_fcs = 0;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    chk("verdict_valid",    int'(verdict_valid),    int'(e_valid));
    chk("verdict_accept",   int'(verdict_accept),   int'(e_acc));
    chk("err_oversize",     int'(err_oversize),     int'(e_over));
    chk("err_undersize",    int'(err_undersize),    int'(e_under));
    chk("err_len_mismatch", int'(err_len_mismatch), int'(e_mism));
    chk("err_fcs",          int'(err_fcs),          int'(e_fcs));
    chk("cnt_oversize",     int'(cnt_oversize),     c_over);
    chk("cnt_undersize",    int'(cnt_undersize),    c_under);
    chk("cnt_len_mismatch", int'(cnt_len_mismatch), c_mism);
    chk("cnt_fcs",          int'(cnt_fcs),          c_fcs);
  end

  // ---------------- stimulus ----------------
  task automatic send_frame(int n, logic [15:0] fld, bit f, bit a, bit s,
                            int gap_at, bit close, bit clr_last);
    for (int i = 0; i < n; i++) begin
      if (i == gap_at && i != 0) begin
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_valid = 1;
      rx_sof   = (i == 0);
      rx_eof   = close && (i == n - 1);
      rx_data  = (i == 12) ? fld[15:8] : (i == 13) ? fld[7:0] : (8'(i) ^ 8'h5A);
      rx_fcs_err   = (i == n - 1) && f;
      rx_align_err = (i == n - 1) && a;
      rx_sym_err   = (i == n - 1) && s;
      clr_stats    = (i == n - 1) && clr_last;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 8'h00;
    rx_fcs_err = 0; rx_align_err = 0; rx_sym_err = 0; clr_stats = 0;
    @(negedge clk);
  endtask

  task automatic frame(int n, logic [15:0] fld, bit f, bit a, bit s);
    send_frame(n, fld, f, a, s, -1, 1, 0);
  endtask

  initial begin
    // R10: outputs zero in reset
    cur_req = "R10";
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: stray beats outside a frame, then a normal frame
    cur_req = "R1";
    rx_valid = 1; rx_eof = 1; rx_data = 8'h11;
    @(negedge clk);
    rx_eof = 0;
    @(negedge clk);
    rx_valid = 0;
    repeat (2) @(negedge clk);
    frame(64, 16'h0800, 0, 0, 0);

    // R2: idle beats inside a frame, restart on a second start beat
    cur_req = "R2";
    send_frame(64, 16'h0800, 0, 0, 0, 30, 1, 0);
    send_frame(40, 16'h0800, 0, 0, 0, -1, 0, 0);
    frame(63, 16'h0800, 0, 0, 0);
    send_frame(70, 16'h0800, 0, 0, 0, -1, 0, 0);
    frame(64, 16'h0800, 0, 0, 0);

    // R3: each limit, on both sides
    cur_req = "R3";
    frame(1518, 16'h0800, 0, 0, 0);
    frame(1519, 16'h0800, 0, 0, 0);
    cfg_ext_size = 1;
    frame(1536, 16'h0800, 0, 0, 0);
    frame(1537, 16'h0800, 0, 0, 0);
    cfg_jumbo = 1;
    frame(10240, 16'h0800, 0, 0, 0);
    frame(10241, 16'h0800, 0, 0, 0);
    cfg_ext_size = 0;
    frame(1600, 16'h0800, 0, 0, 0);
    cfg_jumbo = 0;
    frame(1600, 16'h0800, 0, 0, 0);

    // R4: length field checks
    cur_req = "R4";
    cfg_len_check = 1;
    frame(64, 16'd46, 0, 0, 0);
    frame(64, 16'd47, 0, 0, 0);
    frame(64, 16'h0600, 0, 0, 0);
    frame(64, 16'h05FF, 0, 0, 0);
    frame(13, 16'h0100, 0, 0, 0);
    frame(10, 16'h0100, 0, 0, 0);
    cfg_len_check = 0;
    frame(64, 16'd47, 0, 0, 0);

    // R5: undersize only when clean
    cur_req = "R5";
    frame(63, 16'h0800, 0, 0, 0);
    frame(63, 16'h0800, 1, 0, 0);
    frame(63, 16'h0800, 0, 1, 0);
    frame(63, 16'h0800, 0, 0, 1);
    frame(1, 16'h0800, 0, 0, 0);

    // R6: CRC error, counted and tolerated
    cur_req = "R6";
    frame(100, 16'h0800, 1, 0, 0);
    cfg_fcs_ignore = 1;
    frame(100, 16'h0800, 1, 0, 0);
    frame(63, 16'h0800, 1, 0, 0);
    cfg_fcs_ignore = 0;

    // R7: alignment and symbol errors
    cur_req = "R7";
    frame(100, 16'h0800, 0, 1, 0);
    frame(100, 16'h0800, 0, 0, 1);

    // R8: saturation
    cur_req = "R8";
    for (int k = 0; k < 260; k++) frame(20, 16'h0800, 0, 0, 0);

    // R9: clear, alone and together with a counted verdict
    cur_req = "R9";
    @(negedge clk); clr_stats = 1;
    @(negedge clk); clr_stats = 0;
    frame(20, 16'h0800, 0, 0, 0);
    send_frame(20, 16'h0800, 0, 0, 0, -1, 1, 1);
    frame(2000, 16'h0800, 1, 0, 0);

    // R10: reset in the middle of a frame
    cur_req = "R10";
    send_frame(30, 16'h0800, 0, 0, 0, -1, 0, 0);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    rx_valid = 1; rx_eof = 1;
    @(negedge clk);
    rx_valid = 0; rx_eof = 0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule